// File: doc/BRIEF.md
# Serial Identifier Responder

This block answers a one-cycle request strobe by shifting out a fixed identifier, one bit per clock cycle, on a single data line. The identifier is fixed when the design is built and is not programmable at run time. The default identifier is four bits wide with value 1101, and it goes out most significant bit first. A second output frames the bits so that a receiver knows which cycles carry identifier data.

The block is a Moore machine. It has an idle state and one transmit state for each identifier bit. The outputs depend on the state alone, so a request seen at a clock edge affects the outputs from the next cycle on. The machine does not look at the request line while a transmission runs. After the last bit it always spends at least one cycle idle, so a request held high produces a repeating pattern: one idle cycle, then four data cycles.

Top module: `serial_id_responder`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the machine goes idle, and `id_valid` and `id_bit` are 0 in the following cycle.
- R2: While idle, a clock edge with `req` at 0 keeps the machine idle, with `id_valid` and `id_bit` both 0.
- R3: While idle, a clock edge with `req` at 1 starts a transmission. In the next cycle `id_valid` is 1 and `id_bit` carries the first identifier bit.
- R4: A transmission puts the identifier bits on `id_bit` one per cycle, highest bit first. For the default value 1101 the sequence is 1, 1, 0, 1.
- R5: `id_valid` stays 1 for exactly four consecutive cycles per transmission (one cycle per identifier bit).
- R6: `req` has no effect during a transmission. It neither restarts the transmission nor lengthens it, and the bit sequence and `id_valid` are the same whatever `req` does.
- R7: After the last bit the machine returns to idle whatever `req` is. With `req` held high, exactly one idle cycle separates two transmissions.
- R8: `id_bit` is 0 whenever `id_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Request strobe, sampled only while idle |
| id_bit | output | 1 | Serial identifier data |
| id_valid | output | 1 | High in each cycle that carries an identifier bit |

## Verification
The bench drives every possible 10-cycle request pattern from a fresh reset. This covers these cases:
- a lone strobe, which shows the bit order and the start latency;
- a strobe held high, which shows the forced idle gap between transmissions;
- strobes that toggle during a transmission, which must leave the output unchanged;
- strobes that arrive on the exact cycle the machine returns to idle.

The bench predicts every output from the requirements alone. A separate directed case pulls reset in the middle of a transmission, which shows that reset overrides a send in progress.

// File: rtl/sid_pkg.sv
// Package sid_pkg
// Holds the types and defaults shared by the serial identifier responder.
// Assumes the identifier has at least two bits.
package sid_pkg;
    localparam int unsigned SID_BITS_DEFAULT = 4;

    // Phase of the responder: idle or sending identifier bits.
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_SEND = 1'b1
    } sid_phase_e;
endpackage

// File: rtl/sid_seq.sv
// Module sid_seq
// Holds the state of the responder: the phase, plus the index of the bit now
// being sent. It leaves idle on a sampled request, steps one bit per cycle,
// and after the last bit goes back to idle whatever the request does.
// Assumes ID_BITS >= 2. Reset is synchronous and active low.
module sid_seq
    import sid_pkg::*;
#(
    parameter int unsigned ID_BITS = SID_BITS_DEFAULT,
    localparam int unsigned IW = $clog2(ID_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    output sid_phase_e    phase,
    output logic [IW-1:0] idx
);
    localparam logic [IW-1:0] LAST_IDX = IW'(ID_BITS - 1);

    sid_phase_e    phase_q, phase_d;
    logic [IW-1:0] idx_q, idx_d;

    // Next state: leave idle on a request, step through the bits, always return to idle.
    always_comb begin
        phase_d = phase_q;
        idx_d   = idx_q;
        unique case (phase_q)
            PH_IDLE: begin
                idx_d = '0;
                if (req) phase_d = PH_SEND;
            end
            PH_SEND: begin
                if (idx_q == LAST_IDX) begin
                    phase_d = PH_IDLE;
                    idx_d   = '0;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            default: begin
                phase_d = PH_IDLE;
                idx_d   = '0;
            end
        endcase
    end

    // State register with synchronous active-low reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            idx_q   <= '0;
        end else begin
            phase_q <= phase_d;
            idx_q   <= idx_d;
        end
    end

    assign phase = phase_q;
    assign idx   = idx_q;
endmodule

// File: rtl/sid_decode.sv
// Module sid_decode
// Moore output decode. Each transmit state carries one fixed identifier bit.
// Position 0 is the highest bit of ID_VALUE. Both outputs are 0 while idle.
// Assumes idx stays below ID_BITS while phase is PH_SEND.
module sid_decode
    import sid_pkg::*;
#(
    parameter int unsigned ID_BITS = SID_BITS_DEFAULT,
    parameter logic [ID_BITS-1:0] ID_VALUE = 4'b1101,
    localparam int unsigned IW = $clog2(ID_BITS)
) (
    input  sid_phase_e    phase,
    input  logic [IW-1:0] idx,
    output logic          id_bit,
    output logic          id_valid
);
    logic [ID_BITS-1:0] state_hit;
    logic [ID_BITS-1:0] state_bit;

    // One decoder per transmit state, each with its identifier bit fixed at build time.
    for (genvar g = 0; g < ID_BITS; g++) begin : g_state
        assign state_hit[g] = (phase == PH_SEND) && (idx == IW'(g));
        assign state_bit[g] = ID_VALUE[ID_BITS-1-g];
    end

    // Merge the per-state bits into the serial output.
    always_comb begin
        id_bit   = |(state_hit & state_bit);
        id_valid = (phase == PH_SEND);
    end
endmodule

// File: rtl/serial_id_responder.sv
// Module serial_id_responder
// Top level. After a sampled request it sends a fixed identifier bit-serially,
// highest bit first, with a framing strobe. It does not look at requests
// while a transmission is running.
// Assumes a single clock and a synchronous active-low reset.
module serial_id_responder
    import sid_pkg::*;
#(
    parameter int unsigned ID_BITS = SID_BITS_DEFAULT,
    parameter logic [ID_BITS-1:0] ID_VALUE = 4'b1101
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic id_bit,
    output logic id_valid
);
    localparam int unsigned IW = $clog2(ID_BITS);

    sid_phase_e    phase;
    logic [IW-1:0] idx;

    // Sequencer: phase and bit index.
    sid_seq #(.ID_BITS(ID_BITS)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .phase (phase),
        .idx   (idx)
    );

    // Output decode from the state.
    sid_decode #(.ID_BITS(ID_BITS), .ID_VALUE(ID_VALUE)) u_dec (
        .phase    (phase),
        .idx      (idx),
        .id_bit   (id_bit),
        .id_valid (id_valid)
    );
endmodule

// File: rtl/sid_chk.sv
// Module sid_chk
// Assertion checker for serial_id_responder, watching its ports only.
// It keeps its own count of how many bits the current transmission has sent.
module sid_chk #(
    parameter int unsigned ID_BITS = 4,
    parameter logic [ID_BITS-1:0] ID_VALUE = 4'b1101,
    localparam int unsigned CW = $clog2(ID_BITS + 1)
) (
    input logic clk,
    input logic rst_n,
    input logic req,
    input logic id_bit,
    input logic id_valid
);
    logic [CW-1:0] sent_q;

    // Count the valid cycles in the current run; clear the count when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)        sent_q <= '0;
        else if (id_valid) sent_q <= sent_q + 1'b1;
        else               sent_q <= '0;
    end

    // R1: reset forces idle outputs in the next cycle.
    assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |=> (!id_valid && !id_bit));

    // R2: idle with no request stays idle.
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!id_valid && !req) |=> !id_valid);

    // R3: idle with a request starts a transmission.
    assert_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!id_valid && req) |=> id_valid);

    // R4: each framed bit matches the identifier, highest bit first.
    assert_bit_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && sent_q < CW'(ID_BITS)) |-> id_bit == ID_VALUE[ID_BITS-1-int'(sent_q)]);

    // R5: a run never goes past ID_BITS cycles.
    assert_run_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid |-> sent_q < CW'(ID_BITS));

    // R6: a run that has started keeps going until its last bit, whatever req does.
    assert_no_cut_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && sent_q < CW'(ID_BITS - 1)) |=> id_valid);

    // R7: the last bit is always followed by an idle cycle.
    assert_return_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (id_valid && sent_q == CW'(ID_BITS - 1)) |=> !id_valid);

    // R8: data is 0 when not framed.
    assert_quiet_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !id_valid |-> !id_bit);
endmodule

bind serial_id_responder sid_chk #(.ID_BITS(ID_BITS), .ID_VALUE(ID_VALUE)) u_sid_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .id_bit   (id_bit),
    .id_valid (id_valid)
);

// File: tb/tb_serial_id_responder.sv
// Bench for serial_id_responder.
// Applies every 10-cycle request pattern from reset, then a reset in the middle of a send.
// A model built from the requirements predicts each output cycle.
module tb_serial_id_responder;
    localparam logic [3:0] ID = 4'b1101;
    localparam int NB = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic id_bit, id_valid;
    int   n_tests = 0;
    int   n_fail = 0;
    int   pos = 0;   // model: 0 idle, 1..NB = sending bit number pos

    always #5 clk = ~clk;

    serial_id_responder dut (
        .clk(clk), .rst_n(rst_n), .req(req),
        .id_bit(id_bit), .id_valid(id_valid)
    );

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // Drive req at a falling edge, let one rising edge pass, then check at the next falling edge.
    task automatic step(input logic a);
        int prev;
        string vtag, btag;
        prev = pos;
        req = a;
        @(negedge clk);
        if (prev == 0)       pos = a ? 1 : 0;
        else if (prev == NB) pos = 0;
        else                 pos = prev + 1;
        if (prev == NB)                  vtag = "R7";
        else if (prev == 0 && a)         vtag = "R3";
        else if (prev == 0)              vtag = "R2";
        else if (a)                      vtag = "R6";
        else                             vtag = "R5";
        btag = (pos == 0) ? "R8" : "R4";
        check(vtag, id_valid, logic'(pos != 0), "id_valid");
        check(btag, id_bit, (pos == 0) ? 1'b0 : ID[NB-pos], "id_bit");
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req = 1'b0;
        @(negedge clk);
        @(negedge clk);
        pos = 0;
        check("R1", id_valid, 1'b0, "id_valid after reset");
        check("R1", id_bit, 1'b0, "id_bit after reset");
        rst_n = 1'b1;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        // Sweep every 10-cycle request pattern.
        for (int p = 0; p < 1024; p++) begin
            for (int c = 0; c < 10; c++) step(logic'((p >> c) & 1));
            do_reset();
        end
        // R1: reset in the middle of a send overrides it.
        step(1'b1);
        step(1'b0);
        step(1'b0);
        do_reset();
        step(1'b0);
        // R7: a held request gives one idle cycle between sends.
        for (int c = 0; c < 12; c++) step(1'b1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule